// File: doc/BRIEF.md
# UART Receiver with Character Queue and Receive Flow Control

This block is the receive half of an asynchronous serial port. It oversamples the RX line on a 16x baud tick, assembles 8-bit characters with optional odd or even parity, and stores each one together with its break, framing and parity flags in a four-entry queue. Received characters leave the block on a valid/ready stream, and the error status is shown on a small status bus.

Two mode registers share one address. An internal pointer picks which one an access reaches, and any access to the first register moves the pointer to the second. A command input can move the pointer back to the first register, or clear the accumulated error status. The block can drive RTS low to hold off the far-end sender when the queue is full. A request output follows either "character available" or "queue full", as the mode selects.

Stream rules: `out_valid_o` is high whenever at least one character is held, and `out_data_o` shows the oldest one. A character is removed in a cycle where `out_valid_o` and `out_ready_i` are both high. The producer side has no back-pressure. A character that completes while the queue is full is discarded.

Top module: `uart_rx_fc`

## Requirements
- R1: After reset or a pointer-reset command (`cmd_code_i`=1 with `cmd_valid_i`), a mode access reaches mode register 1. A read or write of mode register 1 moves the pointer to mode register 2, and later accesses stay on mode register 2. Both registers reset to 0.
- R2: Frame format is one start bit (low), 8 data bits LSB first, an optional parity bit and one stop bit, sampled at 16 ticks per bit. A start is accepted only if RX is still low at the middle sample of the start bit. The stop bit is sampled at its middle.
- R3: Mode 1 bits [4:3] select parity: 01 even, 10 odd, 00 or 11 none. With parity on, a wrong parity bit sets the character's parity flag (`stat_o[0]`).
- R4: A stop bit sampled low sets the framing flag (`stat_o[1]`). A character whose data, parity and stop bits are all zero also sets the break flag (`stat_o[2]`).
- R5: The queue holds 4 characters and delivers them in arrival order on the valid/ready stream.
- R6: A character that completes while the queue holds 4 is discarded, and it sets the sticky overrun flag `stat_o[3]`.
- R7: With receive RTS control on (mode 1 bit 0) and transmit RTS control off (mode 2 bit 0), `rts_o` goes low when a valid start bit is seen while the queue is full.
- R8: Under receive RTS control, `rts_o` returns high as soon as the queue has a free entry.
- R9: If receive RTS control is off, or both RTS controls are on, `rts_o` stays high.
- R10: Mode 1 bit 1 selects the `req_o` source: 0 means at least one character is held, 1 means the queue is full.
- R11: With mode 1 bit 2 clear (character mode), `stat_o[2:0]` shows the flags of the head character, or zero when the queue is empty.
- R12: With mode 1 bit 2 set (block mode), `stat_o[2:0]` is the OR of the flags of every character that reached the head since the last error-reset command (`cmd_code_i`=2). That command also clears overrun and leaves the queued characters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial receive line |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| mode_wr_i | input | 1 | Write the mode register the pointer selects |
| mode_rd_i | input | 1 | Read strobe, which advances the pointer |
| mode_wdata_i | input | 8 | Mode write data |
| mode_rdata_o | output | 8 | Mode register the pointer selects |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 2 | 1 = reset pointer, 2 = reset error status |
| out_data_o | output | 8 | Head character |
| out_valid_o | output | 1 | Queue not empty |
| out_ready_i | input | 1 | Consumer accepts the head character |
| stat_o | output | 4 | {overrun, break, framing, parity} |
| rts_o | output | 1 | Request-to-send, high = may send |
| req_o | output | 1 | Interrupt or DMA request |

## Verification
The bench fills the queue and sends a fifth character. A design that pushed on full would overwrite data or fail to set overrun. A design that dropped RTS on the count alone, rather than on the start bit, would show RTS low before the fifth frame begins. Block mode is tested by popping a bad-parity character and checking that its flag stays set until the error-reset command, which must leave the remaining character in place. The pointer is driven through reads, writes and the reset command to catch a pointer that never advances or fails to stick. Break and framing frames, conflicting RTS settings and both request sources are also exercised.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_RST_PTR = 2'd1,
    CMD_RST_ERR = 2'd2,
    CMD_SPARE   = 2'd3
  } cmd_e;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_char_t;

  typedef struct packed {
    logic       rx_rts_en;
    logic       req_full;
    logic       blk_err;
    logic [1:0] par_mode;
    logic       tx_rts_en;
  } rx_cfg_t;
endpackage

// File: rtl/uart_rx_mode_regs.sv
module uart_rx_mode_regs
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_code_i,
  output rx_cfg_t    cfg_o
);
  logic       sel2;
  logic [7:0] mr1, mr2;
  logic       ptr_clr;

  assign ptr_clr = cmd_valid_i && (cmd_e'(cmd_code_i) == CMD_RST_PTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel2 <= 1'b0;
      mr1  <= '0;
      mr2  <= '0;
    end else begin
      if (wr_i) begin
        if (sel2) mr2 <= wdata_i;
        else      mr1 <= wdata_i;
      end
      if (ptr_clr)                     sel2 <= 1'b0;
      else if ((wr_i || rd_i) && !sel2) sel2 <= 1'b1;
    end
  end

  assign rdata_o = sel2 ? mr2 : mr1;

  always_comb begin
    cfg_o.rx_rts_en = mr1[0];
    cfg_o.req_full  = mr1[1];
    cfg_o.blk_err   = mr1[2];
    cfg_o.par_mode  = mr1[4:3];
    cfg_o.tx_rts_en = mr2[0];
  end

  // R1: an access to register 1 moves the pointer on
  a_r1_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel2 && (wr_i || rd_i) && !ptr_clr) |=> sel2);
  // R1: the pointer stays on register 2 until the reset command
  a_r1_ptr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sel2 && !ptr_clr) |=> sel2);
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] par_mode_i,
  output logic       start_ok_o,
  output logic       done_o,
  output rx_char_t   char_o
);
  localparam int OVS      = 16;
  localparam int CW       = $clog2(OVS);
  localparam int NBITS    = 8;
  localparam int BW       = $clog2(NBITS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} st_e;

  st_e             st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   nbit;
  logic [7:0]      sh;
  logic            pbit;
  logic            rx_q1, rx_s;
  logic            par_en, par_odd, ones;

  assign par_en  = (par_mode_i == 2'b01) || (par_mode_i == 2'b10);
  assign par_odd = (par_mode_i == 2'b10);
  assign ones    = (^sh) ^ pbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_s  <= 1'b1;
    end else begin
      rx_q1 <= rx_i;
      rx_s  <= rx_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      nbit       <= '0;
      sh         <= '0;
      pbit       <= 1'b0;
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      char_o     <= '0;
    end else begin
      start_ok_o <= 1'b0;
      done_o     <= 1'b0;
      case (st)
        S_IDLE: if (tick_i && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick_i) begin
          if (cnt == MID) begin
            cnt  <= '0;
            nbit <= '0;
            pbit <= 1'b0;
            if (!rx_s) begin
              st         <= S_DATA;
              start_ok_o <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick_i) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            sh   <= {rx_s, sh[7:1]};
            nbit <= nbit + 1'b1;
            if (nbit == BW'(NBITS - 1)) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick_i) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            pbit <= rx_s;
            st   <= S_STOP;
          end
        end
        S_STOP: if (tick_i) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            done_o      <= 1'b1;
            char_o.data <= sh;
            char_o.fe   <= !rx_s;
            char_o.brk  <= (sh == 8'h00) && !pbit && !rx_s;
            char_o.pe   <= par_en && (par_odd ? !ones : ones);
            st          <= rx_s ? S_IDLE : S_WAITHI;
          end
        end
        default: if (rx_s) st <= S_IDLE;
      endcase
    end
  end

  // R2: each completed character is a single pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R4: a break character is always a framing error too
  a_r4_brk_has_fe: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && char_o.brk) |-> char_o.fe);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push_i,
  input  rx_char_t din_i,
  input  logic     pop_i,
  output rx_char_t head_o,
  output logic     full_o,
  output logic     empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  rx_char_t      mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PLAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PLAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5: occupancy never exceeds the depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R6: a push while full with no pop leaves the queue full and unchanged
  a_r6_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(wp)));
endmodule

// File: rtl/uart_rx_fc.sv
module uart_rx_fc
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       baud_tick_i,
  input  logic       mode_wr_i,
  input  logic       mode_rd_i,
  input  logic [7:0] mode_wdata_i,
  output logic [7:0] mode_rdata_o,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_code_i,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [3:0] stat_o,
  output logic       rts_o,
  output logic       req_o
);
  rx_cfg_t  cfg;
  rx_char_t rx_char, head;
  logic     start_ok, done, full, empty, pop;
  logic     ovr, head_seen, rts_q, rts_ctl_en, clr_err;
  logic [2:0] acc;

  uart_rx_mode_regs u_mode (
    .clk(clk), .rst_n(rst_n), .wr_i(mode_wr_i), .rd_i(mode_rd_i),
    .wdata_i(mode_wdata_i), .rdata_o(mode_rdata_o),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .cfg_o(cfg)
  );

  uart_rx_deser u_deser (
    .clk(clk), .rst_n(rst_n), .tick_i(baud_tick_i), .rx_i(rx_i),
    .par_mode_i(cfg.par_mode), .start_ok_o(start_ok), .done_o(done),
    .char_o(rx_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(done), .din_i(rx_char),
    .pop_i(pop), .head_o(head), .full_o(full), .empty_o(empty)
  );

  assign clr_err    = cmd_valid_i && (cmd_e'(cmd_code_i) == CMD_RST_ERR);
  assign rts_ctl_en = cfg.rx_rts_en && !cfg.tx_rts_en;
  assign pop        = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr       <= 1'b0;
      acc       <= '0;
      head_seen <= 1'b0;
      rts_q     <= 1'b1;
    end else begin
      if (clr_err) begin
        ovr <= 1'b0;
        acc <= '0;
      end else begin
        if (done && full) ovr <= 1'b1;
        if (!empty && !head_seen) acc <= acc | {head.brk, head.fe, head.pe};
      end
      head_seen <= !(pop || empty);
      if (!rts_ctl_en || !full) rts_q <= 1'b1;
      else if (start_ok)        rts_q <= 1'b0;
    end
  end

  assign out_valid_o = !empty;
  assign out_data_o  = head.data;
  assign rts_o       = rts_q;
  assign req_o       = cfg.req_full ? full : !empty;
  assign stat_o      = {ovr, cfg.blk_err ? acc
                                         : (empty ? 3'b000 : {head.brk, head.fe, head.pe})};

  // R7: RTS only falls after a full queue under receive control
  a_r7_rts_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_o) |-> ($past(full) && $past(rts_ctl_en)));
  // R9: conflicting RTS settings keep RTS high
  a_r9_conflict_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rx_rts_en && cfg.tx_rts_en) |=> rts_o);
  // R6: overrun is sticky until the error-reset command
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[3] && !clr_err) |=> stat_o[3]);
  // R11: character mode shows no flags when nothing is held
  a_r11_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.blk_err && !out_valid_o) |-> (stat_o[2:0] == 3'b000));
  // R10: request from the full source implies the stream has data
  a_r10_req_full_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> out_valid_o);
endmodule

// File: tb/tb_uart_rx_fc.sv
module tb_uart_rx_fc;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, tick = 1'b0;
  logic mwr = 1'b0, mrd = 1'b0, cvalid = 1'b0, ready = 1'b0;
  logic [7:0] mwdata = '0;
  logic [1:0] ccode = '0;
  logic [7:0] mrdata, odata;
  logic ovalid, rts, req;
  logic [3:0] stat;
  int checks = 0, fails = 0, tdiv = 1, tcnt = 0, cyc = 0;
  bit done_run = 1'b0;

  uart_rx_fc dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_tick_i(tick),
    .mode_wr_i(mwr), .mode_rd_i(mrd), .mode_wdata_i(mwdata), .mode_rdata_o(mrdata),
    .cmd_valid_i(cvalid), .cmd_code_i(ccode), .out_data_o(odata),
    .out_valid_o(ovalid), .out_ready_i(ready), .stat_o(stat), .rts_o(rts), .req_o(req)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    tick <= (tcnt == 0);
    cyc  <= cyc + 1;
  end

  initial begin
    wait (cyc > 150000);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input int pm);
    return (pm == 2) ? ~^d : ^d;
  endfunction

  task automatic bitwait();
    repeat (16 * tdiv) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int pm, input bit flip, input bit stopb);
    rx = 1'b0; bitwait();
    for (int i = 0; i < 8; i++) begin rx = d[i]; bitwait(); end
    if (pm == 1 || pm == 2) begin rx = par_of(d, pm) ^ flip; bitwait(); end
    rx = stopb; bitwait();
    rx = 1'b1; bitwait(); bitwait();
  endtask

  task automatic mwrite(input logic [7:0] v);
    @(negedge clk); mwr = 1'b1; mwdata = v;
    @(negedge clk); mwr = 1'b0;
  endtask

  task automatic mread(output logic [7:0] v);
    @(negedge clk); mrd = 1'b1; #1 v = mrdata;
    @(negedge clk); mrd = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] c);
    @(negedge clk); cvalid = 1'b1; ccode = c;
    @(negedge clk); cvalid = 1'b0; ccode = '0;
  endtask

  task automatic modes(input logic [7:0] m1, input logic [7:0] m2);
    cmd(2'd1); mwrite(m1); mwrite(m2);
  endtask

  task automatic pop(output logic [7:0] d, output logic [3:0] s);
    int w = 0;
    @(negedge clk);
    while (!ovalid && w < 200) begin @(negedge clk); w++; end
    d = odata; s = stat;
    ready = 1'b1; @(negedge clk); ready = 1'b0;
  endtask

  task automatic drain();
    logic [7:0] d; logic [3:0] s;
    @(negedge clk);
    while (ovalid) pop(d, s);
    cmd(2'd2);
  endtask

  initial begin
    logic [7:0] v, d;
    logic [3:0] s;
    logic [7:0] q [4];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset rts", rts, 1);
    chk("R10 reset req", req, 0);
    chk("R5 reset valid", ovalid, 0);
    chk("R11 reset stat", stat, 0);

    // R1 pointer
    mread(v); chk("R1 first read hits mr1", v, 8'h00);
    mwrite(8'hA5); mread(v); chk("R1 mr2 after advance", v, 8'hA5);
    mread(v); chk("R1 pointer stays on mr2", v, 8'hA5);
    cmd(2'd1); mwrite(8'h18); cmd(2'd1); mread(v); chk("R1 reset pointer to mr1", v, 8'h18);
    mread(v); chk("R1 mr2 kept", v, 8'hA5);
    modes(8'h00, 8'h00);

    // R2 R3 R5 random
    for (int it = 0; it < 10; it++) begin
      int pm; bit flip; logic [7:0] dd;
      pm = $urandom_range(0, 2); tdiv = $urandom_range(1, 3);
      dd = 8'($urandom); flip = (pm != 0) && ($urandom_range(0, 3) == 0);
      modes(8'(pm << 3), 8'h00);
      send(dd, pm, flip, 1'b1);
      pop(d, s);
      chk("R2 random data", d, dd);
      chk("R3 random parity flag", s, {3'b000, flip});
    end
    tdiv = 1;

    // R2 glitch start rejected
    @(negedge clk); rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (400) @(negedge clk);
    chk("R2 short glitch no char", ovalid, 0);

    // R4 framing and break
    modes(8'h00, 8'h00);
    send(8'h5A, 0, 0, 1'b0); pop(d, s);
    chk("R4 framing data", d, 8'h5A); chk("R4 framing flags", s, 4'b0010);
    send(8'h00, 0, 0, 1'b0); pop(d, s);
    chk("R4 break flags", s, 4'b0110);

    // R11 character mode head status
    modes(8'h10, 8'h00);
    send(8'h33, 2, 1, 1'b1); send(8'h44, 2, 0, 1'b1);
    pop(d, s); chk("R11 head bad parity", s, 4'b0001);
    pop(d, s); chk("R11 next head clean", s, 4'b0000);
    chk("R11 data order", d, 8'h44);

    // R10 request source
    modes(8'h02, 8'h00);
    for (int i = 0; i < 3; i++) send(8'(8'h10 + i), 0, 0, 1'b1);
    chk("R10 full source not full", req, 0);
    send(8'h13, 0, 0, 1'b1);
    chk("R10 full source full", req, 1);
    pop(d, s); @(negedge clk); chk("R10 full source after pop", req, 0);
    drain();
    modes(8'h00, 8'h00);
    send(8'h77, 0, 0, 1'b1); chk("R10 ready source", req, 1);
    drain();

    // R6 R7 R8 overrun and RTS
    modes(8'h01, 8'h00);
    for (int i = 0; i < 4; i++) begin q[i] = 8'($urandom); send(q[i], 0, 0, 1'b1); end
    chk("R7 rts high before start", rts, 1);
    fork send(8'hEE, 0, 0, 1'b1); join_none
    repeat (16 * 3) @(negedge clk);
    chk("R7 rts low on start while full", rts, 0);
    wait fork;
    chk("R6 overrun set", stat[3], 1);
    cmd(2'd2); chk("R12 clear overrun", stat[3], 0);
    pop(d, s); chk("R5 order 0 kept after clear", d, q[0]);
    repeat (2) @(negedge clk); chk("R8 rts back high", rts, 1);
    for (int i = 1; i < 4; i++) begin pop(d, s); chk("R6 queued data intact", d, q[i]); end
    @(negedge clk); chk("R6 extra char discarded", ovalid, 0);

    // R9 conflict
    modes(8'h01, 8'h01);
    for (int i = 0; i < 4; i++) send(8'(i), 0, 0, 1'b1);
    fork send(8'hEE, 0, 0, 1'b1); join_none
    repeat (16 * 3) @(negedge clk);
    chk("R9 conflict keeps rts", rts, 1);
    wait fork;
    drain();

    // R12 block mode
    modes(8'h0C, 8'h00);
    send(8'h21, 1, 1, 1'b1); send(8'h22, 1, 0, 1'b1);
    pop(d, s); repeat (3) @(negedge clk);
    chk("R12 block keeps parity flag", stat[2:0], 3'b001);
    cmd(2'd2); repeat (2) @(negedge clk);
    chk("R12 cleared status", stat, 4'b0000);
    chk("R12 fifo untouched valid", ovalid, 1);
    chk("R12 fifo untouched data", odata, 8'h22);
    drain();

    done_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule